// File: doc/BRIEF.md
# Two-Strike Watchdog Timer

This block is a watchdog timer that software configures through a small register port with single-cycle writes and combinational reads. Once armed, it counts oscillator ticks in units of a power-of-two prescaler. A full period is the programmed number of units plus one. A period that runs out with no keep-alive raises an interrupt. If a second period then runs out back-to-back, the block asserts its reset output. A keep-alive write restarts the count and withdraws the interrupt. Software can also force a parity fault that asserts the reset output on the next clock edge. The fault can instead be routed to a sticky status flag.

The period value is frozen once the timer is armed. Arming cannot be undone by software. Only the module reset input disarms the timer, clears every register and releases the reset output. The control is a four-state machine:

- `ST_IDLE` (disarmed) goes to `ST_RUN` on an arm write.
- `ST_RUN` (counting) goes to `ST_WARN` on an expiry.
- `ST_WARN` (interrupt raised) returns to `ST_RUN` on a keep-alive, and goes to `ST_BITE` on a second expiry.
- Every state except `ST_BITE` goes to `ST_BITE` on a routed parity fault.
- `ST_BITE` (reset asserted) is left only through the module reset.

Register offsets:

| Offset | Register | Write | Read |
|---|---|---|---|
| 0x00 | Control | bit 0 = 1 arms the timer | bit 0 = armed |
| 0x04 | Period | bits [31:20] set the period | bits [31:20] = period, lower bits zero |
| 0x08 | Lapsed count | any write clears the count | bits [11:0] = completed prescaler units in the current period |
| 0x0C | Keep-alive | bit 0 = 1 is a keep-alive | bit 0 = interrupt |
| 0x10 | Fault routing | bit 0 selects the route | bit 0 = route |
| 0x14 | Fault force | bit 0 = 1 forces a parity fault | bit 0 = fault flag |

Top module: `wdt_dual_ovf`

## Requirements
- R1: After the module reset input (`rst_n` low, asynchronous), every readable register reads zero, `irq` and `wdt_rst` are low, and the timer is disarmed.
- R2: A write to the period register at offset 0x04 keeps only bits [31:20]. Bits [19:0] are dropped and read back as zero.
- R3: Once the timer is armed by writing 1 to bit 0 of the control register at offset 0x00, writes to the period register have no effect. Writing 0 to the control register does not disarm the timer.
- R4: With period value N and prescaler length P = 2^PRE_LOG2, `irq` rises at the clock edge that counts the P*(N+1)-th `osc_tick` after arming. Cycles with `osc_tick` low do not count.
- R5: Writing 1 to bit 0 of offset 0x0C is a keep-alive. It clears the lapsed count and drops `irq`, and the next expiry is again a first expiry. A keep-alive in the same cycle as an expiry takes priority over the expiry.
- R6: A second expiry with no keep-alive between the two raises `wdt_rst`. `wdt_rst` then stays high, even through keep-alives, until `rst_n` is applied.
- R7: Any write to offset 0x08 clears the lapsed count and prescaler but leaves `irq` unchanged.
- R8: If fault-routing bit 0 at offset 0x10 is 0, writing 1 to bit 0 of offset 0x14 raises `wdt_rst` at the next clock edge, whether or not the timer is armed.
- R9: If fault-routing bit 0 is 1, the same forced fault instead sets a sticky flag, read at offset 0x14 bit 0, and `wdt_rst` stays low.
- R10: Reads are combinational and follow the offset table above. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Module reset, active low, asynchronous |
| osc_tick | input | 1 | One pulse per oscillator cycle, already synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset for both read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for reg_addr |
| irq | output | 1 | First-expiry interrupt |
| wdt_rst | output | 1 | Watchdog reset request |

## Verification
The bench builds the block with PRE_LOG2 = 4, so one prescaler unit is 16 ticks instead of about a million. With periods of 0 to 3, the first and second expiry are reached within 16 to 128 ticks. This makes the exact expiry edge, the tie between a keep-alive and an expiry, and the sticky reset practical to hit many times within one run. A random phase is also included: gaps in `osc_tick`, keep-alives, count clears and routed faults are compared cycle by cycle with a tick-counting model in the bench.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_WARN,
        ST_BITE
    } wdt_state_t;

    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_PERIOD = 'h04;
    localparam int OFS_LAPSED = 'h08;
    localparam int OFS_KICK   = 'h0C;
    localparam int OFS_PE_CTL = 'h10;
    localparam int OFS_PE_FRC = 'h14;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5,
    parameter int PERIOD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [PERIOD_W-1:0] lapsed,
    input  logic                irq,
    output logic [PERIOD_W-1:0] period_q,
    output logic                enabled_q,
    output logic                pe_ctrl_q,
    output logic                pe_flag_q,
    output logic                arm,
    output logic                kick,
    output logic                cnt_clr,
    output logic                force_rst,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int LOW_W = DATA_W - PERIOD_W;

    logic sel_ctrl, sel_period, sel_lapsed, sel_kick, sel_pe_ctl, sel_pe_frc;
    logic pe_force;

    always_comb begin
        sel_ctrl   = wr_en && (reg_addr == ADDR_W'(OFS_CTRL));
        sel_period = wr_en && (reg_addr == ADDR_W'(OFS_PERIOD));
        sel_lapsed = wr_en && (reg_addr == ADDR_W'(OFS_LAPSED));
        sel_kick   = wr_en && (reg_addr == ADDR_W'(OFS_KICK));
        sel_pe_ctl = wr_en && (reg_addr == ADDR_W'(OFS_PE_CTL));
        sel_pe_frc = wr_en && (reg_addr == ADDR_W'(OFS_PE_FRC));
        pe_force   = sel_pe_frc && wr_data[0];
        arm        = sel_ctrl && wr_data[0] && !enabled_q;
        kick       = sel_kick && wr_data[0];
        cnt_clr    = kick || sel_lapsed;
        force_rst  = pe_force && !pe_ctrl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q  <= '0;
            enabled_q <= 1'b0;
            pe_ctrl_q <= 1'b0;
            pe_flag_q <= 1'b0;
        end else begin
            if (sel_period && !enabled_q) begin
                period_q <= wr_data[DATA_W-1 -: PERIOD_W];
            end
            if (arm) begin
                enabled_q <= 1'b1;
            end
            if (sel_pe_ctl) begin
                pe_ctrl_q <= wr_data[0];
            end
            if (pe_force && pe_ctrl_q) begin
                pe_flag_q <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (reg_addr)
            ADDR_W'(OFS_CTRL):   rd_data[0] = enabled_q;
            ADDR_W'(OFS_PERIOD): rd_data = {period_q, {LOW_W{1'b0}}};
            ADDR_W'(OFS_LAPSED): rd_data[PERIOD_W-1:0] = lapsed;
            ADDR_W'(OFS_KICK):   rd_data[0] = irq;
            ADDR_W'(OFS_PE_CTL): rd_data[0] = pe_ctrl_q;
            ADDR_W'(OFS_PE_FRC): rd_data[0] = pe_flag_q;
            default:             rd_data = '0;
        endcase
    end
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
    parameter int PRE_LOG2 = 20,
    parameter int PERIOD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                tick,
    input  logic                clr,
    input  logic [PERIOD_W-1:0] period,
    output logic [PERIOD_W-1:0] lapsed,
    output logic                expire
);
    localparam logic [PRE_LOG2-1:0] PRE_LAST = '1;

    logic [PRE_LOG2-1:0] pre_q;
    logic                unit_done;

    always_comb begin
        unit_done = run && tick && (pre_q == PRE_LAST);
        expire    = unit_done && !clr && (lapsed == period);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            lapsed <= '0;
        end else if (clr) begin
            pre_q  <= '0;
            lapsed <= '0;
        end else if (run && tick) begin
            pre_q <= pre_q + 1'b1;
            if (unit_done) begin
                lapsed <= (lapsed == period) ? '0 : lapsed + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic kick,
    input  logic expire,
    input  logic force_rst,
    output logic run,
    output logic irq,
    output logic wdt_rst
);
    wdt_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (force_rst)   state_d = ST_BITE;
                else if (arm)    state_d = ST_RUN;
            end
            ST_RUN: begin
                if (force_rst)   state_d = ST_BITE;
                else if (expire) state_d = ST_WARN;
            end
            ST_WARN: begin
                if (force_rst)   state_d = ST_BITE;
                else if (kick)   state_d = ST_RUN;
                else if (expire) state_d = ST_BITE;
            end
            ST_BITE: state_d = ST_BITE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run     = (state_q == ST_RUN) || (state_q == ST_WARN);
        irq     = (state_q == ST_WARN);
        wdt_rst = (state_q == ST_BITE);
    end
endmodule

// File: rtl/wdt_dual_ovf.sv
module wdt_dual_ovf #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5,
    parameter int PERIOD_W = 12,
    parameter int PRE_LOG2 = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              wdt_rst
);
    logic [PERIOD_W-1:0] period_q;
    logic [PERIOD_W-1:0] lapsed;
    logic enabled_q, pe_ctrl_q, pe_flag_q;
    logic arm, kick, cnt_clr, force_rst, run, expire;

    wdt_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .lapsed(lapsed), .irq(irq),
        .period_q(period_q), .enabled_q(enabled_q), .pe_ctrl_q(pe_ctrl_q),
        .pe_flag_q(pe_flag_q), .arm(arm), .kick(kick), .cnt_clr(cnt_clr),
        .force_rst(force_rst), .rd_data(rd_data)
    );

    wdt_timebase #(
        .PRE_LOG2(PRE_LOG2), .PERIOD_W(PERIOD_W)
    ) u_timebase (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(osc_tick), .clr(cnt_clr),
        .period(period_q), .lapsed(lapsed), .expire(expire)
    );

    wdt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .arm(arm), .kick(kick), .expire(expire),
        .force_rst(force_rst), .run(run), .irq(irq), .wdt_rst(wdt_rst)
    );
endmodule

// File: rtl/wdt_dual_ovf_chk.sv
module wdt_dual_ovf_chk #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5,
    parameter int PERIOD_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic                irq,
    input logic                wdt_rst,
    input logic                enabled,
    input logic [PERIOD_W-1:0] period,
    input logic                pe_ctrl,
    input logic                pe_flag
);
    logic frc_wr, kick_wr;
    assign frc_wr  = wr_en && (reg_addr == ADDR_W'('h14)) && wr_data[0];
    assign kick_wr = wr_en && (reg_addr == ADDR_W'('h0C)) && wr_data[0];

    a_r6_bite_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> wdt_rst);
    a_r3_period_locked: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |=> $stable(period));
    a_r3_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |=> enabled);
    a_r8_force_bites: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_wr && !pe_ctrl) |=> wdt_rst);
    a_r9_force_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_wr && pe_ctrl) |=> pe_flag);
    a_r5_kick_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_wr && !wdt_rst && !(frc_wr && !pe_ctrl)) |=> !irq);
    a_r6_no_irq_in_bite: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && wdt_rst));
endmodule

bind wdt_dual_ovf wdt_dual_ovf_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .irq(irq), .wdt_rst(wdt_rst), .enabled(enabled_q),
    .period(period_q), .pe_ctrl(pe_ctrl_q), .pe_flag(pe_flag_q)
);

// File: tb/wdt_dual_ovf_bench.sv
module wdt_dual_ovf_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PRE_L      = 4;
    localparam int P          = 1 << PRE_L;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq, wdt_rst;

    int n_chk = 0;
    int n_fail = 0;

    bit r_en, r_run, r_phase, r_bite, r_pe_ctrl, r_pe_flag;
    int r_ticks, r_period;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_dual_ovf #(.PRE_LOG2(PRE_L)) u_wdt_dual_ovf (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wr_en(wr_en),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
        .irq(irq), .wdt_rst(wdt_rst)
    );

    function automatic bit exp_irq();
        return r_run && r_phase && !r_bite;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(bit w, logic [4:0] a, logic [31:0] d, bit t);
        bit kick, lclr, frc;
        int lim;
        lim  = P * (r_period + 1);
        kick = w && a == 5'h0C && d[0];
        lclr = w && a == 5'h08;
        frc  = w && a == 5'h14 && d[0];
        if (!r_bite) begin
            if (frc && !r_pe_ctrl) begin
                r_bite = 1; r_run = 0;
            end else begin
                if (kick || lclr) begin
                    r_ticks = 0;
                    if (kick) r_phase = 0;
                end else if (r_run && t) begin
                    r_ticks++;
                    if (r_ticks == lim) begin
                        r_ticks = 0;
                        if (r_phase) begin r_bite = 1; r_run = 0; end
                        else r_phase = 1;
                    end
                end
                if (!r_run && w && a == 5'h00 && d[0] && !r_en) r_run = 1;
            end
        end
        if (w && a == 5'h04 && !r_en) r_period = int'(d[31:20]);
        if (w && a == 5'h00 && d[0]) r_en = 1;
        if (frc && r_pe_ctrl) r_pe_flag = 1;
        if (w && a == 5'h10) r_pe_ctrl = d[0];
    endtask

    task automatic cyc(bit w, logic [4:0] a, logic [31:0] d, bit t);
        @(negedge clk);
        wr_en = w; reg_addr = a; wr_data = d; osc_tick = t;
        model(w, a, d, t);
        @(posedge clk);
        #1;
        wr_en = 0; osc_tick = 0;
        chk("R4 R5 R6 model irq", {31'b0, irq}, {31'b0, exp_irq()});
        chk("R6 R8 model wdt_rst", {31'b0, wdt_rst}, {31'b0, r_bite});
    endtask

    task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        wr_en = 0; osc_tick = 0; reg_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; wr_en = 0; osc_tick = 0;
        r_en = 0; r_run = 0; r_phase = 0; r_bite = 0;
        r_pe_ctrl = 0; r_pe_flag = 0; r_ticks = 0; r_period = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // R1: reset state
        for (int i = 0; i < 6; i++) rd(5'(i * 4), 32'h0, "R1 reset readback");
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R1 wdt_rst after reset", {31'b0, wdt_rst}, 32'h0);

        // R2: period field masking
        cyc(1, 5'h04, 32'hFFFF_FFFF, 0);
        rd(5'h04, 32'hFFF0_0000, "R2 period mask");
        cyc(1, 5'h04, 32'h001A_BCDE, 0);
        rd(5'h04, 32'h0010_0000, "R2 period low bits dropped");

        // R3: lock after arming
        cyc(1, 5'h00, 32'h1, 0);
        rd(5'h00, 32'h1, "R10 control reads armed");
        cyc(1, 5'h04, 32'h0050_0000, 0);
        rd(5'h04, 32'h0010_0000, "R3 period locked");
        cyc(1, 5'h00, 32'h0, 0);
        rd(5'h00, 32'h1, "R3 arm not cleared");

        // R4: first expiry exactly at 2*P ticks (N=1)
        for (int i = 0; i < 2 * P - 1; i++) cyc(0, 5'h00, 0, 1);
        chk("R4 irq low one tick early", {31'b0, irq}, 32'h0);
        cyc(0, 5'h00, 0, 0);
        chk("R4 gap tick not counted", {31'b0, irq}, 32'h0);
        cyc(0, 5'h00, 0, 1);
        chk("R4 irq at expiry", {31'b0, irq}, 32'h1);
        rd(5'h0C, 32'h1, "R10 kick reg reads irq");

        // R7: lapsed clear keeps irq
        for (int i = 0; i < P; i++) cyc(0, 5'h00, 0, 1);
        rd(5'h08, 32'h1, "R10 lapsed units");
        cyc(1, 5'h08, 32'h0, 0);
        rd(5'h08, 32'h0, "R7 lapsed cleared");
        chk("R7 irq kept", {31'b0, irq}, 32'h1);

        // R5: keep-alive, and tie with expiry
        cyc(1, 5'h0C, 32'h1, 0);
        chk("R5 kick drops irq", {31'b0, irq}, 32'h0);
        for (int i = 0; i < 2 * P - 1; i++) cyc(0, 5'h00, 0, 1);
        cyc(1, 5'h0C, 32'h1, 1);
        chk("R5 kick beats expiry", {31'b0, irq}, 32'h0);
        for (int i = 0; i < 2 * P; i++) cyc(0, 5'h00, 0, 1);
        chk("R5 fresh first expiry", {31'b0, irq}, 32'h1);

        // R6: second expiry bites and sticks
        for (int i = 0; i < 2 * P - 1; i++) cyc(0, 5'h00, 0, 1);
        chk("R6 no bite one tick early", {31'b0, wdt_rst}, 32'h0);
        cyc(0, 5'h00, 0, 1);
        chk("R6 bite on second expiry", {31'b0, wdt_rst}, 32'h1);
        for (int i = 0; i < 5; i++) cyc(1, 5'h0C, 32'h1, 1);
        chk("R6 bite sticky through kicks", {31'b0, wdt_rst}, 32'h1);
        do_reset();
        chk("R6 released by module reset", {31'b0, wdt_rst}, 32'h0);

        // R9 then R8
        cyc(1, 5'h10, 32'h1, 0);
        rd(5'h10, 32'h1, "R10 routing readback");
        cyc(1, 5'h14, 32'h1, 0);
        chk("R9 no reset when routed", {31'b0, wdt_rst}, 32'h0);
        rd(5'h14, 32'h1, "R9 fault flag set");
        rd(5'h18, 32'h0, "R10 unmapped reads zero");
        cyc(1, 5'h10, 32'h0, 0);
        cyc(1, 5'h14, 32'h1, 0);
        chk("R8 forced reset while disarmed", {31'b0, wdt_rst}, 32'h1);

        // random phase
        for (int round = 0; round < 4; round++) begin
            do_reset();
            cyc(1, 5'h04, 32'($urandom_range(0, 3)) << 20, 0);
            cyc(1, 5'h10, 32'($urandom_range(0, 1)), 0);
            cyc(1, 5'h00, 32'h1, 0);
            for (int i = 0; i < 1500; i++) begin
                int op;
                bit t;
                op = $urandom_range(0, 999);
                t  = ($urandom_range(0, 3) != 0);
                if (op < 25)       cyc(1, 5'h0C, 32'h1, t);
                else if (op < 35)  cyc(1, 5'h08, 32'h0, t);
                else if (op < 37)  cyc(1, 5'h14, 32'h1, t);
                else if (op < 40)  cyc(1, 5'h04, 32'hFFF0_0000, t);
                else               cyc(0, 5'h00, 32'h0, t);
            end
            rd(5'h14, {31'b0, r_pe_flag}, "R9 random flag");
        end
        finish_run();
    end
endmodule